// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block decides how a processor core enters an exception. Each cycle it looks at the set of pending exception causes and at the program counter it holds. When a cause is accepted, it picks the handler address, saves the current program counter into one of two return-address registers and updates the interrupt-enable state. All of this happens on one clock edge. When no cause is accepted, the program counter simply loads the sequential next address supplied by the core.

Causes are split into two groups. Debug causes (breakpoint, watchpoint) always vector through the debug base and save into the breakpoint-return register. Ordinary causes (instruction bus error, data bus error, divide by zero, external interrupt, system call) save into the exception-return register and vector through the normal base, unless the remap bit is set. The two vector bases, the remap bit and the three enable bits can be written by the core through simple write strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the program counter equals the RESET_PC parameter. Both return registers and all three enable bits are zero, and both bases hold their reset parameters. The remap bit is clear and no exception is signalled.
- R2: Cause numbers are: 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call. Input bit k of `pend_i` requests cause k. When several causes are accepted together, the lowest number is taken, and `take_o`/`cause_o` report it in the same cycle.
- R3: Cause 6 (interrupt) is accepted only while the global enable is 1. When it is masked, other pending causes are still taken, and with nothing else pending the program counter follows `nxt_pc_i`.
- R4: An ordinary exception copies the current program counter into the exception-return register and leaves the breakpoint-return register unchanged.
- R5: A debug exception (cause 1 or 3) copies the current program counter into the breakpoint-return register and leaves the exception-return register unchanged.
- R6: On an ordinary exception, the saved exception-enable bit becomes 1 if the global enable was 1 and is otherwise unchanged. The global enable clears and the saved breakpoint-enable bit is unchanged.
- R7: On a debug exception, the saved breakpoint-enable bit becomes 1 if the global enable was 1 and is otherwise unchanged. The global enable clears and the saved exception-enable bit is unchanged.
- R8: The new program counter is the selected base plus the cause number times 32. An ordinary exception uses the normal base while the remap bit is 0 and the debug base while it is 1.
- R9: A debug exception uses the debug base whatever the remap bit holds.
- R10: In a cycle with no exception, the program counter loads `nxt_pc_i` and both return registers hold their values.
- R11: A base write through `base_we_i` (bit 0 normal base, bit 1 debug base) stores `base_wd_i` with its low 8 bits forced to zero. The new base is used from the next cycle on.
- R12: `ie_we_i` loads `ie_wd_i` (bit 0 global enable, bit 1 saved exception-enable, bit 2 saved breakpoint-enable) when no exception is taken. In a cycle where an exception is taken the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 7 | Pending causes, bit k requests cause k (k = 1..7) |
| nxt_pc_i | input | AW | Sequential next program counter from the core |
| base_we_i | input | 2 | Base write strobes: bit 0 normal, bit 1 debug |
| base_wd_i | input | AW | Base write data |
| remap_we_i | input | 1 | Remap bit write strobe |
| remap_wd_i | input | 1 | Remap bit write data |
| ie_we_i | input | 1 | Enable bits write strobe |
| ie_wd_i | input | 3 | Enable write data {bie, eie, ie} |
| take_o | output | 1 | An exception is taken this cycle |
| cause_o | output | 3 | Number of the cause being taken |
| pc_o | output | AW | Program counter |
| ea_o | output | AW | Exception-return register |
| ba_o | output | AW | Breakpoint-return register |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Saved exception-enable bit |
| bie_o | output | 1 | Saved breakpoint-enable bit |

## Verification
The hardest situation to reach is a taken exception that meets a particular enable state. Every accepted exception clears the global enable, so the saved-enable bits only become 1 if the enable is first restored through the write port. An interrupt can be accepted only in that restored window. The stimulus therefore interleaves enable writes with pending causes in directed sequences: an enable restore followed by a breakpoint under remap, a masked interrupt next to a data bus error, and an enable write in the very cycle an exception is taken. A long random phase then sends sparse multi-cause requests and occasional enable and base writes. The bench's own model follows all of it cycle by cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W   = 3;
  localparam int STRIDE_LG = 5;
  localparam int OFF_W     = CAUSE_W + STRIDE_LG;
  localparam int NCAUSE    = 1 << CAUSE_W;

  localparam logic [CAUSE_W-1:0] C_RESET = 3'd0;
  localparam logic [CAUSE_W-1:0] C_BRK   = 3'd1;
  localparam logic [CAUSE_W-1:0] C_IBUS  = 3'd2;
  localparam logic [CAUSE_W-1:0] C_WATCH = 3'd3;
  localparam logic [CAUSE_W-1:0] C_DBUS  = 3'd4;
  localparam logic [CAUSE_W-1:0] C_DIV0  = 3'd5;
  localparam logic [CAUSE_W-1:0] C_IRQ   = 3'd6;
  localparam logic [CAUSE_W-1:0] C_SCALL = 3'd7;

  // debug group: breakpoint and watchpoint
  function automatic logic is_debug(input logic [CAUSE_W-1:0] c);
    return (c == C_BRK) || (c == C_WATCH);
  endfunction

  // offset inside the vector page: cause * 2**STRIDE_LG
  function automatic logic [OFF_W-1:0] vec_off(input logic [CAUSE_W-1:0] c);
    return {c, {STRIDE_LG{1'b0}}};
  endfunction
endpackage

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int NC = NCAUSE
) (
  input  logic [NC-1:1]      pend,
  input  logic               gie,
  output logic               take,
  output logic [CAUSE_W-1:0] cause
);
  logic [NC-1:1] live;

  for (genvar g = 1; g < NC; g++) begin : g_mask
    if (g == int'(C_IRQ)) begin : g_irq
      assign live[g] = pend[g] & gie;
    end else begin : g_plain
      assign live[g] = pend[g];
    end
  end

  // lowest number wins: scan downward so the last hit is the lowest
  always_comb begin
    cause = C_RESET;
    for (int k = NC - 1; k >= 1; k--) begin
      if (live[k]) cause = CAUSE_W'(k);
    end
  end

  assign take = |live;
endmodule

// File: rtl/exc_vec.sv
module exc_vec
  import exc_pkg::*;
#(
  parameter int           AW       = 32,
  parameter logic [AW-1:0] EBA_RST  = '0,
  parameter logic [AW-1:0] DEBA_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         base_we,
  input  logic [AW-1:0]      base_wd,
  input  logic               remap_we,
  input  logic               remap_wd,
  input  logic [CAUSE_W-1:0] cause,
  output logic               remap,
  output logic [AW-1:0]      vec
);
  localparam int HW = AW - OFF_W;

  logic [HW-1:0] eba_hi, deba_hi;
  logic          use_dbg_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eba_hi  <= EBA_RST[AW-1:OFF_W];
      deba_hi <= DEBA_RST[AW-1:OFF_W];
      remap   <= 1'b0;
    end else begin
      if (base_we[0]) eba_hi  <= base_wd[AW-1:OFF_W];
      if (base_we[1]) deba_hi <= base_wd[AW-1:OFF_W];
      if (remap_we)   remap   <= remap_wd;
    end
  end

  assign use_dbg_base = is_debug(cause) || remap;
  assign vec = {use_dbg_base ? deba_hi : eba_hi, vec_off(cause)};
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [AW-1:0]      vec,
  input  logic [AW-1:0]      nxt_pc,
  input  logic               ie_we,
  input  logic [2:0]         ie_wd,
  output logic [AW-1:0]      pc,
  output logic [AW-1:0]      ea,
  output logic [AW-1:0]      ba,
  output logic               gie,
  output logic               eie,
  output logic               bie
);
  logic dbg;
  assign dbg = is_debug(cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      ea  <= '0;
      ba  <= '0;
      gie <= 1'b0;
      eie <= 1'b0;
      bie <= 1'b0;
    end else if (take) begin
      pc  <= vec;
      gie <= 1'b0;
      if (dbg) begin
        ba  <= pc;
        bie <= bie | gie;
      end else begin
        ea  <= pc;
        eie <= eie | gie;
      end
    end else begin
      pc <= nxt_pc;
      if (ie_we) {bie, eie, gie} <= ie_wd;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] EBA_RST  = '0,
  parameter logic [AW-1:0] DEBA_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCAUSE-1:1]  pend_i,
  input  logic [AW-1:0]      nxt_pc_i,
  input  logic [1:0]         base_we_i,
  input  logic [AW-1:0]      base_wd_i,
  input  logic               remap_we_i,
  input  logic               remap_wd_i,
  input  logic               ie_we_i,
  input  logic [2:0]         ie_wd_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      pc_o,
  output logic [AW-1:0]      ea_o,
  output logic [AW-1:0]      ba_o,
  output logic               ie_o,
  output logic               eie_o,
  output logic               bie_o
);
  logic [AW-1:0] vec_w;
  logic          remap_w;

  exc_pick #(.NC(NCAUSE)) u_pick (
    .pend (pend_i),
    .gie  (ie_o),
    .take (take_o),
    .cause(cause_o)
  );

  exc_vec #(.AW(AW), .EBA_RST(EBA_RST), .DEBA_RST(DEBA_RST)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_we (base_we_i),
    .base_wd (base_wd_i),
    .remap_we(remap_we_i),
    .remap_wd(remap_wd_i),
    .cause   (cause_o),
    .remap   (remap_w),
    .vec     (vec_w)
  );

  exc_state #(.AW(AW), .RESET_PC(RESET_PC)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_o),
    .cause (cause_o),
    .vec   (vec_w),
    .nxt_pc(nxt_pc_i),
    .ie_we (ie_we_i),
    .ie_wd (ie_wd_i),
    .pc    (pc_o),
    .ea    (ea_o),
    .ba    (ba_o),
    .gie   (ie_o),
    .eie   (eie_o),
    .bie   (bie_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCAUSE-1:1]  pend,
  input logic [AW-1:0]      nxt_pc,
  input logic               take,
  input logic [CAUSE_W-1:0] cause,
  input logic [AW-1:0]      pc,
  input logic [AW-1:0]      ea,
  input logic [AW-1:0]      ba,
  input logic               gie,
  input logic               eie,
  input logic               bie
);
  // R2
  cause_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cause != C_RESET) && pend[cause]);

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cause == C_IRQ) |-> gie);

  // R4
  ord_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_debug(cause)) |=> (ea == $past(pc)) && $stable(ba));

  // R5
  dbg_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_debug(cause)) |=> (ba == $past(pc)) && $stable(ea));

  // R6
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  // R6
  eie_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_debug(cause) && gie) |=> eie && $stable(bie));

  // R7
  bie_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_debug(cause) && gie) |=> bie && $stable(eie));

  // R8
  vec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc[OFF_W-1:0] == {$past(cause), {STRIDE_LG{1'b0}}});

  // R10
  idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (pc == $past(nxt_pc)) && $stable(ea) && $stable(ba));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pend  (pend_i),
  .nxt_pc(nxt_pc_i),
  .take  (take_o),
  .cause (cause_o),
  .pc    (pc_o),
  .ea    (ea_o),
  .ba    (ba_o),
  .gie   (ie_o),
  .eie   (eie_o),
  .bie   (bie_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  pend = '0;
  logic [31:0] nxt_pc = '0;
  logic [1:0]  base_we = '0;
  logic [31:0] base_wd = '0;
  logic        remap_we = 1'b0, remap_wd = 1'b0;
  logic        ie_we = 1'b0;
  logic [2:0]  ie_wd = '0;
  logic        take_o;
  logic [2:0]  cause_o;
  logic [31:0] pc_o, ea_o, ba_o;
  logic        ie_o, eie_o, bie_o;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .nxt_pc_i(nxt_pc),
    .base_we_i(base_we), .base_wd_i(base_wd),
    .remap_we_i(remap_we), .remap_wd_i(remap_wd),
    .ie_we_i(ie_we), .ie_wd_i(ie_wd),
    .take_o(take_o), .cause_o(cause_o), .pc_o(pc_o), .ea_o(ea_o), .ba_o(ba_o),
    .ie_o(ie_o), .eie_o(eie_o), .bie_o(bie_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  logic [31:0] m_pc = '0, m_ea = '0, m_ba = '0, m_eba = '0, m_deba = '0;
  bit m_ie = 0, m_eie = 0, m_bie = 0, m_re = 0;
  int last_cause = 0;

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    pend = '0; base_we = '0; remap_we = 1'b0; ie_we = 1'b0;
  endtask

  // one cycle: called at a negedge with inputs already driven
  task automatic step();
    int c;
    bit dbg;
    logic [31:0] base, n_pc, n_ea, n_ba;
    bit n_ie, n_eie, n_bie;
    #2;
    c = 0;
    for (int k = 1; k < 8; k++)
      if (c == 0 && pend[k] && (k != 6 || m_ie)) c = k;
    last_cause = c;
    cmp("R2", "take", {31'b0, take_o}, {31'b0, c != 0});
    if (c != 0) cmp("R2", "cause", {29'b0, cause_o}, c);
    n_pc = m_pc; n_ea = m_ea; n_ba = m_ba;
    n_ie = m_ie; n_eie = m_eie; n_bie = m_bie;
    if (c != 0) begin
      dbg  = (c == 1) || (c == 3);
      base = (dbg || m_re) ? m_deba : m_eba;
      n_pc = base + c * 32;
      if (dbg) begin n_ba = m_pc; if (m_ie) n_bie = 1; end
      else     begin n_ea = m_pc; if (m_ie) n_eie = 1; end
      n_ie = 0;
    end else begin
      n_pc = nxt_pc;
      if (ie_we) begin n_ie = ie_wd[0]; n_eie = ie_wd[1]; n_bie = ie_wd[2]; end
    end
    @(posedge clk);
    if (base_we[0]) m_eba  = base_wd & 32'hFFFF_FF00;
    if (base_we[1]) m_deba = base_wd & 32'hFFFF_FF00;
    if (remap_we) m_re = remap_wd;
    m_pc = n_pc; m_ea = n_ea; m_ba = n_ba;
    m_ie = n_ie; m_eie = n_eie; m_bie = n_bie;
    @(negedge clk);
    cmp("R8", "pc", pc_o, m_pc);
    cmp("R4", "ea", ea_o, m_ea);
    cmp("R5", "ba", ba_o, m_ba);
    cmp("R6", "ie", {31'b0, ie_o}, {31'b0, m_ie});
    cmp("R6", "eie", {31'b0, eie_o}, {31'b0, m_eie});
    cmp("R7", "bie", {31'b0, bie_o}, {31'b0, m_bie});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    cmp("R1", "pc", pc_o, 32'h0);
    cmp("R1", "ea", ea_o, 32'h0);
    cmp("R1", "ba", ba_o, 32'h0);
    cmp("R1", "enables", {29'b0, bie_o, eie_o, ie_o}, 32'h0);
    cmp("R1", "take", {31'b0, take_o}, 32'h0);
    @(negedge clk);

    // R11 base writes drop the low byte
    idle(); base_we = 2'b01; base_wd = 32'h1000_00FF; nxt_pc = 32'h0000_0004; step();
    idle(); base_we = 2'b10; base_wd = 32'h2000_0055; nxt_pc = 32'h0000_0008; step();
    idle(); ie_we = 1'b1; ie_wd = 3'b001; nxt_pc = 32'h0000_000C; step();
    idle(); pend[2] = 1'b1; step();
    cmp("R11", "ibus vector", pc_o, 32'h1000_0040);
    cmp("R4", "ea saved", ea_o, 32'h0000_000C);
    cmp("R6", "eie set", {31'b0, eie_o}, 32'h1);

    // R3 interrupt masked with enable clear
    idle(); pend[6] = 1'b1; nxt_pc = 32'h0000_0200; step();
    cmp("R3", "masked irq take", {31'b0, take_o}, 32'h0);
    cmp("R3", "pc follows", pc_o, 32'h0000_0200);
    idle(); pend[6] = 1'b1; pend[4] = 1'b1; step();
    cmp("R3", "other cause taken", pc_o, 32'h1000_0080);

    // R10 sequential flow
    idle(); nxt_pc = 32'h0000_0300; step();
    cmp("R10", "pc loads next", pc_o, 32'h0000_0300);

    // R9 debug cause ignores remap, R7 bie saved
    idle(); remap_we = 1'b1; remap_wd = 1'b1; step();
    idle(); ie_we = 1'b1; ie_wd = 3'b001; step();
    idle(); pend[1] = 1'b1; step();
    cmp("R9", "brk vector", pc_o, 32'h2000_0020);
    cmp("R7", "bie set", {31'b0, bie_o}, 32'h1);
    idle(); pend[5] = 1'b1; step();
    cmp("R8", "remapped div0", pc_o, 32'h2000_00A0);

    // R2 lowest number wins
    idle(); pend[7] = 1'b1; pend[5] = 1'b1; pend[3] = 1'b1; step();
    cmp("R2", "watch over others", pc_o, 32'h2000_0060);

    // R12 enable write dropped while an exception is taken
    idle(); ie_we = 1'b1; ie_wd = 3'b001; pend[7] = 1'b1; step();
    cmp("R12", "ie after take", {31'b0, ie_o}, 32'h0);
    idle(); ie_we = 1'b1; ie_wd = 3'b001; step();
    idle(); pend[6] = 1'b1; step();
    cmp("R3", "irq accepted", {29'b0, cause_o}, 32'h0);
    cmp("R3", "irq vector", pc_o, 32'h2000_00C0);
    idle(); remap_we = 1'b1; remap_wd = 1'b0; step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int k = 1; k < 8; k++) pend[k] = ($urandom % 6 == 0);
      nxt_pc = $urandom & 32'hFFFF_FFFC;
      if ($urandom % 5 == 0) begin ie_we = 1'b1; ie_wd = 3'($urandom); end
      if ($urandom % 40 == 0) begin base_we = 2'($urandom); base_wd = $urandom; end
      if ($urandom % 25 == 0) begin remap_we = 1'b1; remap_wd = 1'($urandom); end
      step();
    end
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule